// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind the receive parser of an Ethernet MAC and decides, once per frame, whether the frame is kept or dropped. The decision depends only on the 48-bit destination address. The parser presents that address with a one-cycle strobe. One clock later the block returns a one-cycle verdict.

Four policies combine into that verdict. A promiscuous override accepts everything. Broadcast frames are accepted unless a broadcast-drop bit is set. A group (multicast) address can pass in one of two ways: a pass-all-multicast switch, or a lookup in a hash bin table indexed by CRC-32 bits. A unicast address must exactly equal one of a small set of programmed entries. Entry 0 conventionally holds the station address.

Mode bits, hash bins and address entries are loaded through a synchronous write port that takes an index and 32 bits of data. A write issued in the same cycle as an address strobe applies only to later frames.

Top module: `rx_da_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0 and every mode bit, hash bin and table word is 0. Each `da_valid` strobe yields exactly one `dec_valid` pulse in the following cycle. `dec_valid` is 0 in every cycle that does not follow a strobe.
- R2: When mode bit 0 (promiscuous, write index 0) is set, every frame is accepted, whatever the address, bins or table hold.
- R3: The all-ones address is accepted when mode bit 3 (broadcast drop) is clear. It is dropped when that bit is set, unless promiscuous mode is on.
- R4: An address is a group address when `da[0]` is set. `da[7:0]` is the first byte on the wire. When mode bit 1 (pass all multicast) is set, every non-broadcast group address is accepted without a hash lookup.
- R5: The bin index is computed as follows. Run the reflected Ethernet CRC-32 (polynomial 0xEDB88320) over `da[0]` through `da[47]` in that order, starting from all ones. Invert the result and bit-reverse it. The top HASH_BITS bits of that value form the index.
- R6: The index bits above the low five select the hash word, which is written at index 8 + word. The low five bits select the bit within that word.
- R7: With mode bit 2 (hash multicast) set and mode bit 1 clear, a non-broadcast group address is accepted exactly when its bin bit is 1. With mode bits 1 and 2 both clear, such an address is dropped.
- R8: A unicast address (`da[0]` = 0) is accepted exactly when it equals an entry of the table. Entry k has its low word `da[31:0]` at index 32 + 2k and its high word `da[47:32]` in bits 15:0 at index 33 + 2k. Bits 31:16 of a high-word write are ignored.
- R9: An entry whose two words are both zero never matches. The all-zero address is therefore dropped unless promiscuous mode is on.
- R10: A register write in the same cycle as `da_valid` does not affect that frame's decision. It applies to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first wire byte in bits 7:0 |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 6 | Register write index |
| wr_data | input | 32 | Register write data |
| dec_valid | output | 1 | Decision strobe, one cycle after `da_valid` |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop; meaningful with `dec_valid` |

## Verification
The hardest case to reach is a multicast address landing on one chosen hash bin with that bin's bit set and every neighbouring bit clear. Random addresses and random bin contents almost never isolate a single bin. The stimulus therefore computes the bin of a chosen group address in the bench. It then programs only that bit, and afterwards every bit except that one, and checks that the verdict flips. Two other cases also need precise stimulus. One is a write in the same cycle as the strobe. The other is a unicast address differing from a table entry in one bit or only in ignored high-word bits. The bench drives each of these directly, and random mixes of table copies, broadcast, zero and random addresses cover the rest.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

   localparam int IDX_W      = 6;
   localparam int ADDR_W     = 48;
   localparam int WORD_W     = 32;
   localparam int HI_W       = ADDR_W - WORD_W;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   // write index map
   localparam logic [IDX_W-1:0] IDX_MODE = 6'd0;
   localparam logic [2:0]       IDX_HASH_TAG = 3'b001;  // 8..15

   typedef struct packed {
      logic bcast_drop;  // bit 3
      logic hash_mc;     // bit 2
      logic all_mc;      // bit 1
      logic promisc;     // bit 0
   } mode_t;

endpackage

// File: rtl/rx_da_crc_hash.sv
module rx_da_crc_hash
   import rx_da_filter_pkg::*;
#(
   parameter int HASH_BITS = 8
)(
   input  logic [ADDR_W-1:0]    addr,
   output logic [HASH_BITS-1:0] bin_idx
);

   logic [31:0] crc;

   always_comb begin
      logic [31:0] c;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < ADDR_W; i++) begin
         fb = c[0] ^ addr[i];
         c  = c >> 1;
         if (fb) c = c ^ CRC_POLY_REFL;
      end
      crc = c;
   end

   // top bits of the reversed complement are the low bits of the complement
   // taken in reverse order: index bit (HASH_BITS-1-j) = ~crc[j]
   for (genvar j = 0; j < HASH_BITS; j++) begin : g_idx
      assign bin_idx[HASH_BITS-1-j] = ~crc[j];
   end

endmodule

// File: rtl/rx_da_hash_bins.sv
module rx_da_hash_bins
   import rx_da_filter_pkg::*;
#(
   parameter int HASH_BITS = 8
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           wr_word,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic [HASH_BITS-1:0] bin_idx,
   output logic                 bin_set
);

   localparam int SEL_W   = HASH_BITS - 5;
   localparam int N_WORDS = 1 << SEL_W;

   if (HASH_BITS < 6 || HASH_BITS > 8) begin : g_bad_bits
      $error("rx_da_hash_bins: HASH_BITS must be 6, 7 or 8");
   end

   logic [WORD_W-1:0] bins_q [N_WORDS];
   logic [SEL_W-1:0]  sel;
   logic [4:0]        bit_pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < N_WORDS; w++) bins_q[w] <= '0;
      end else if (wr_en && (int'(wr_word) < N_WORDS)) begin
         bins_q[wr_word[SEL_W-1:0]] <= wr_data;
      end
   end

   assign sel     = bin_idx[HASH_BITS-1:5];
   assign bit_pos = bin_idx[4:0];
   assign bin_set = bins_q[sel][bit_pos];

endmodule

// File: rtl/rx_da_addr_table.sv
module rx_da_addr_table
   import rx_da_filter_pkg::*;
#(
   parameter int N_ENTRIES = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_entry,
   input  logic              wr_high,
   input  logic [WORD_W-1:0] wr_lo_data,
   input  logic [HI_W-1:0]   wr_hi_data,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   if (N_ENTRIES < 1 || N_ENTRIES > 16) begin : g_bad_entries
      $error("rx_da_addr_table: N_ENTRIES must be 1..16");
   end

   logic [N_ENTRIES-1:0] match;

   for (genvar k = 0; k < N_ENTRIES; k++) begin : g_entry
      logic [WORD_W-1:0] lo_q;
      logic [HI_W-1:0]   hi_q;
      logic              in_use;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (wr_en && (int'(wr_entry) == k)) begin
            if (wr_high) hi_q <= wr_hi_data;
            else         lo_q <= wr_lo_data;
         end
      end

      assign in_use   = (|lo_q) | (|hi_q);
      assign match[k] = in_use && ({hi_q, lo_q} == addr);
   end

   assign hit = |match;

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
   import rx_da_filter_pkg::*;
#(
   parameter int HASH_BITS = 8,
   parameter int N_ENTRIES = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              da_valid,
   input  logic [47:0]       da,
   input  logic              wr_en,
   input  logic [5:0]        wr_idx,
   input  logic [31:0]       wr_data,
   output logic              dec_valid,
   output logic              dec_accept
);

   if (HASH_BITS < 6 || HASH_BITS > 8) begin : g_bad_hash
      $error("rx_da_filter: HASH_BITS must be 6, 7 or 8");
   end
   if (N_ENTRIES < 1 || N_ENTRIES > 16) begin : g_bad_tab
      $error("rx_da_filter: N_ENTRIES must be 1..16");
   end

   // ---------------- write decode ----------------
   mode_t mode_q;
   logic  wr_mode, wr_hash, wr_tab;

   assign wr_mode = wr_en && (wr_idx == IDX_MODE);
   assign wr_hash = wr_en && (wr_idx[5:3] == IDX_HASH_TAG);
   assign wr_tab  = wr_en && wr_idx[5];

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= mode_t'(wr_data[3:0]);
   end

   // ---------------- lookup paths ----------------
   logic [HASH_BITS-1:0] bin_idx;
   logic                 bin_set;
   logic                 tab_hit;

   rx_da_crc_hash #(.HASH_BITS(HASH_BITS)) u_crc (
      .addr    (da),
      .bin_idx (bin_idx)
   );

   rx_da_hash_bins #(.HASH_BITS(HASH_BITS)) u_bins (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hash),
      .wr_word (wr_idx[2:0]),
      .wr_data (wr_data),
      .bin_idx (bin_idx),
      .bin_set (bin_set)
   );

   rx_da_addr_table #(.N_ENTRIES(N_ENTRIES)) u_tab (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_tab),
      .wr_entry   (wr_idx[4:1]),
      .wr_high    (wr_idx[0]),
      .wr_lo_data (wr_data),
      .wr_hi_data (wr_data[HI_W-1:0]),
      .addr       (da),
      .hit        (tab_hit)
   );

   // ---------------- policy ----------------
   logic is_group, is_bcast, accept_d;

   assign is_group = da[0];
   assign is_bcast = &da;

   always_comb begin
      if (mode_q.promisc)   accept_d = 1'b1;
      else if (is_bcast)    accept_d = !mode_q.bcast_drop;
      else if (is_group)    accept_d = mode_q.all_mc | (mode_q.hash_mc & bin_set);
      else                  accept_d = tab_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= da_valid;
         dec_accept <= da_valid & accept_d;
      end
   end

   // ---------------- assertions ----------------
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> dec_valid);  // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !dec_valid);  // R1
   AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && mode_q.promisc) |=> dec_accept);  // R2
   AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && (&da) && !mode_q.bcast_drop) |=> dec_accept);  // R3
   AST_MCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && da[0] && mode_q.all_mc && !mode_q.bcast_drop) |=> dec_accept);  // R4
   AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && (da == 48'h0) && !mode_q.promisc) |=> !dec_accept);  // R9

endmodule

// File: tb/rx_da_filter_bench.sv
module rx_da_filter_bench;

   localparam int HB = 8;
   localparam int NE = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        da_valid;
   logic [47:0] da;
   logic        wr_en;
   logic [5:0]  wr_idx;
   logic [31:0] wr_data;
   logic        dec_valid, dec_accept;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #10 clk = ~clk;  // 50 MHz

   rx_da_filter #(.HASH_BITS(HB), .N_ENTRIES(NE)) u_rx_da_filter (
      .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   // ---------- bench model ----------
   logic [3:0]  m_mode;
   logic [31:0] m_hash [8];
   logic [31:0] m_lo   [NE];
   logic [15:0] m_hi   [NE];

   function automatic int bin_of(input logic [47:0] a);
      logic [31:0] c, inv, rev;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB8_8320;
         else             c = c >> 1;
      end
      inv = ~c;
      for (int i = 0; i < 32; i++) rev[31-i] = inv[i];
      return int'(rev >> (32 - HB));
   endfunction

   function automatic bit expect_acc(input logic [47:0] a);
      int b;
      bit hit;
      if (m_mode[0]) return 1;
      if (a == 48'hFFFF_FFFF_FFFF) return !m_mode[3];
      if (a[0]) begin
         if (m_mode[1]) return 1;
         b = bin_of(a);
         return m_mode[2] && m_hash[b/32][b%32];
      end
      hit = 0;
      for (int k = 0; k < NE; k++)
         if (({m_hi[k], m_lo[k]} != 48'h0) && ({m_hi[k], m_lo[k]} == a)) hit = 1;
      return hit;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [5:0] idx, input logic [31:0] d);
      if (idx == 6'd0) m_mode = d[3:0];
      else if (idx[5:3] == 3'b001) m_hash[idx[2:0]] = d;
      else if (idx[5] && int'(idx[4:1]) < NE) begin
         if (idx[0]) m_hi[idx[4:1]] = d[15:0];
         else        m_lo[idx[4:1]] = d;
      end
   endtask

   task automatic reg_write(input logic [5:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      model_write(idx, d);
   endtask

   // present an address; inputs change at a negedge, outputs sampled one cycle later
   task automatic frame(input logic [47:0] a, input string req);
      bit e;
      e = expect_acc(a);
      @(negedge clk);
      da_valid = 1; da = a;
      @(negedge clk);
      da_valid = 0;
      chk(dec_valid === 1'b1, {req, " valid"}, int'(dec_valid), 1);
      chk(dec_accept === e, {req, " accept"}, int'(dec_accept), int'(e));
   endtask

   function automatic logic [47:0] group_addr_for_bin(input int b);
      logic [47:0] a;
      a = 48'h0000_5E00_0001;
      for (int t = 0; t < 100000; t++) begin
         a[47:24] = 24'(t);
         if (bin_of(a) == b) return a;
      end
      return a;
   endfunction

   initial begin : wd
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [47:0] st, mc;
      int b;
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      rst_n = 0; da_valid = 0; da = '0; wr_en = 0; wr_idx = '0; wr_data = '0;
      m_mode = '0;
      for (int i = 0; i < 8; i++) m_hash[i] = '0;
      for (int k = 0; k < NE; k++) begin m_lo[k] = '0; m_hi[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk(dec_valid === 1'b0, "R1 reset valid", int'(dec_valid), 0);
      chk(dec_accept === 1'b0, "R1 reset accept", int'(dec_accept), 0);
      // R9 empty table never matches the zero address
      frame(48'h0, "R9 zero addr");
      // R3 broadcast accepted by default
      frame(48'hFFFF_FFFF_FFFF, "R3 bcast default");
      // R1 no pulse without a strobe
      @(negedge clk);
      chk(dec_valid === 1'b0, "R1 idle", int'(dec_valid), 0);

      // R8 station address in entry 0
      st = 48'h3412_CDAB_5502;
      reg_write(6'd32, st[31:0]);
      reg_write(6'd33, 32'hABCD_0000 | {16'h0, st[47:32]});  // upper bits ignored
      frame(st, "R8 station hit");
      frame(st ^ 48'h0100_0000_0000, "R8 near miss");
      frame(48'h0000_0000_0002, "R8 miss");
      reg_write(6'd36, 32'h0000_0010);  // entry 2 low only
      frame(48'h0000_0000_0010, "R8 entry2 low only");

      // R7 multicast dropped with no multicast mode
      mc = group_addr_for_bin(77);
      frame(mc, "R7 mcast no mode");
      // R4 pass all multicast
      reg_write(6'd0, 32'h2);
      frame(mc, "R4 all mcast");
      frame(48'hFFFF_FFFF_FFFF, "R3 bcast with allmc");
      // R5 R6 R7 isolate bin 77
      reg_write(6'd0, 32'h4);
      b = bin_of(mc);
      reg_write(6'(8 + b/32), 32'h1 << (b%32));
      frame(mc, "R6 bin set");
      reg_write(6'(8 + b/32), ~(32'h1 << (b%32)));
      frame(mc, "R7 bin clear");
      for (int w = 0; w < 8; w++) if (w != b/32) reg_write(6'(8 + w), 32'hFFFF_FFFF);
      frame(mc, "R5 others set");
      // R3 broadcast drop, then promiscuous overrides (R2)
      reg_write(6'd0, 32'h8);
      frame(48'hFFFF_FFFF_FFFF, "R3 bcast drop");
      reg_write(6'd0, 32'h9);
      frame(48'hFFFF_FFFF_FFFF, "R2 promisc bcast");
      frame(48'h0, "R2 promisc zero");
      frame(48'h1111_2222_3330, "R2 promisc unicast");
      reg_write(6'd0, 32'h0);

      // R10 write in the same cycle as the strobe
      @(negedge clk);
      da_valid = 1; da = st; wr_en = 1; wr_idx = 6'd32; wr_data = 32'h0;
      @(negedge clk);
      da_valid = 0; wr_en = 0;
      chk(dec_valid === 1'b1, "R10 valid", int'(dec_valid), 1);
      chk(dec_accept === 1'b1, "R10 old table used", int'(dec_accept), 1);
      model_write(6'd32, 32'h0);
      frame(st, "R10 next frame new table");

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [47:0] a;
         int cls;
         if ($urandom_range(0, 3) == 0) begin
            int r;
            r = $urandom_range(0, 2);
            if (r == 0) reg_write(6'd0, 32'($urandom_range(0, 15)));
            else if (r == 1) reg_write(6'(8 + $urandom_range(0, 7)), $urandom);
            else reg_write(6'(32 + $urandom_range(0, 2*NE-1)),
                           ($urandom_range(0, 4) == 0) ? 32'h0 : ($urandom & 32'hFFFF_FFFE));
         end
         cls = $urandom_range(0, 4);
         case (cls)
            0: begin
               int k;
               k = $urandom_range(0, NE-1);
               a = {m_hi[k], m_lo[k]};
            end
            1: a = {$urandom, 16'($urandom)} | 48'h1;
            2: a = 48'hFFFF_FFFF_FFFF;
            3: a = {$urandom, 16'($urandom)} & ~48'h1;
            default: a = 48'h0;
         endcase
         frame(a, "R8 R7 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule